// File: doc/BRIEF.md
# GPIO Line Interrupt Detector and Router

This block holds the interrupt half of a general-purpose I/O port. It watches a vector of already synchronized pin levels and, for every line that the build allows to interrupt, turns either a level or an edge of a chosen polarity into a pending flag. The flags are sticky: they stay set until software writes a 1 to them. Lines that the build leaves without interrupt capability have no enable, polarity or edge storage and never raise a flag.

Pending flags are steered onto a vector of interrupt request lines. A build-time capability value picks the steering. In the per-line mode each line drives its own request line. In the shared mode every line drives one request line. In the mapped mode each line carries a 5-bit software-programmable offset. Each request output is the OR of the flags steered to it, and it is registered. Software sees the block through a simple word-addressed register port with a one-cycle read latency.

Top module: `gpio_irq_router`

## Requirements
- R1: After a synchronous active-high reset, the enable, polarity, edge and pending registers are 0, every request output is 0 and `rdata` is 0.
- R2: With edge-select bit 1, a line raises its flag on a 0-to-1 change from one cycle to the next if its polarity bit is 1, and on a 1-to-0 change if its polarity bit is 0. A steady level raises nothing.
- R3: With edge-select bit 0, a line raises its flag in every cycle in which its level equals its polarity bit. This includes the cycle in which software clears the flag, so the flag stays set while the level persists.
- R4: The pending register is at word 4. A read returns the pending flags. A write sets to 0 each flag whose data bit is 1 and leaves the others unchanged. A flag raised in the same cycle as the clear stays set.
- R5: The polarity register (word 2) and the edge register (word 3) keep only the bits of lines enabled in the capability mask `IRQ_CAP`. After all ones are written, each reads back as `IRQ_CAP`. A line outside `IRQ_CAP` never raises a flag.
- R6: The enable register is at word 1 and is limited to `IRQ_CAP`. A flag is raised only for lines whose enable bit is 1. Clearing an enable bit leaves a flag that is already pending unchanged.
- R7: Word 0 is read-only. Bits [4:0] read as `IRQGEN` and all other bits read as 0. Writes to it have no effect.
- R8: With `IRQGEN` = 0, request output number (`IRQ_BASE` + n) mod `NIRQ` carries the flag of line n.
- R9: With `IRQGEN` = 1, request output `IRQ_BASE` mod `NIRQ` is the OR of all flags, and every other request output stays 0.
- R10: With `IRQGEN` from 2 to 31, word 8 + n/4 holds the offset of line n. Line 4k+j uses bits [24-8j+4 : 24-8j], so the lowest line of each word sits in the top byte. The line drives request output (`IRQ_BASE` + offset) mod `NIRQ`. The other bits read as 0. In the other modes these words read as 0 and ignore writes.
- R11: Each request output is registered. It equals the OR of the pending flags steered to it, as they stood one clock earlier.
- R12: `rdata` carries the addressed word in the cycle after `rd_en`, and 0 otherwise. Unused addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_i | input | NL | Synchronized pin levels |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after `rd_en` |
| irq_o | output | NIRQ | Registered interrupt request vector |

## Verification
Three copies, built with `IRQGEN` set to 0, 1 and 5, receive the same pins and the same bus traffic. One flag model and three steering models predict the request vectors on every cycle, so a fault in flag detection shows up in all three copies, while a fault in steering shows up in one. Directed cases run first:
- all ones written to the configuration words, to show which lines are implemented;
- a held level cleared while it is still present, to separate level re-raising from sticky edges;
- a single rising pulse and a falling pulse in edge mode.

Random traffic follows: sparse pin toggles, frequent partial clears, random configurations and map words whose offsets wrap past `NIRQ`. This traffic exercises simultaneous raise and clear, enable removal under a pending flag, and writes to the capability word and to unused addresses.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int REG_W = 32;
  localparam int OFFW  = 5;

  localparam int ADDR_CAP  = 0;
  localparam int ADDR_MASK = 1;
  localparam int ADDR_POL  = 2;
  localparam int ADDR_EDGE = 3;
  localparam int ADDR_FLAG = 4;
  localparam int ADDR_MAP  = 8;

  typedef enum logic [1:0] {
    ROUTE_PER_LINE = 2'd0,
    ROUTE_SHARED   = 2'd1,
    ROUTE_MAPPED   = 2'd2
  } route_e;

  function automatic route_e route_kind(input int irqgen);
    if (irqgen == 0)      return ROUTE_PER_LINE;
    else if (irqgen == 1) return ROUTE_SHARED;
    else                  return ROUTE_MAPPED;
  endfunction

endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int          NL     = 16,
  parameter int          AW     = 4,
  parameter int          IRQGEN = 2,
  parameter logic [NL-1:0] CAP  = '1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [AW-1:0]             addr,
  input  logic [REG_W-1:0]          wdata,
  input  logic [NL-1:0]             flag_i,
  output logic [REG_W-1:0]          rdata,
  output logic [NL-1:0]             mask_o,
  output logic [NL-1:0]             pol_o,
  output logic [NL-1:0]             edge_o,
  output logic [NL-1:0]             clr_o,
  output logic [NL-1:0][OFFW-1:0]   map_o
);

  localparam int     NW   = NL / 4;
  localparam route_e KIND = route_kind(IRQGEN);

  logic [NL-1:0] mask_q, pol_q, edge_q;
  logic [NW-1:0][REG_W-1:0] map_word;
  logic [REG_W-1:0] rd_val;

  logic hit_mask, hit_pol, hit_edge, hit_flag;
  assign hit_mask = wr_en && (addr == AW'(ADDR_MASK));
  assign hit_pol  = wr_en && (addr == AW'(ADDR_POL));
  assign hit_edge = wr_en && (addr == AW'(ADDR_EDGE));
  assign hit_flag = wr_en && (addr == AW'(ADDR_FLAG));

  // Configuration bits exist only for lines in the capability mask.
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      pol_q  <= '0;
      edge_q <= '0;
    end else begin
      if (hit_mask) mask_q <= wdata[NL-1:0] & CAP;
      if (hit_pol)  pol_q  <= wdata[NL-1:0] & CAP;
      if (hit_edge) edge_q <= wdata[NL-1:0] & CAP;
    end
  end

  assign mask_o = mask_q;
  assign pol_o  = pol_q;
  assign edge_o = edge_q;
  assign clr_o  = hit_flag ? wdata[NL-1:0] : '0;

  generate
    if (KIND == ROUTE_MAPPED) begin : g_map
      logic [OFFW-1:0] map_q [NL];
      for (genvar k = 0; k < NW; k++) begin : g_word
        // Lowest line of each word lives in the top byte.
        always_ff @(posedge clk) begin
          if (rst) begin
            for (int j = 0; j < 4; j++) map_q[4*k+j] <= '0;
          end else if (wr_en && (addr == AW'(ADDR_MAP + k))) begin
            for (int j = 0; j < 4; j++) map_q[4*k+j] <= wdata[(24-8*j) +: OFFW];
          end
        end
        assign map_word[k] = {3'b000, map_q[4*k],   3'b000, map_q[4*k+1],
                              3'b000, map_q[4*k+2], 3'b000, map_q[4*k+3]};
      end
      for (genvar n = 0; n < NL; n++) begin : g_out
        assign map_o[n] = map_q[n];
      end
    end else begin : g_nomap
      assign map_word = '0;
      assign map_o    = '0;
    end
  endgenerate

  always_comb begin
    rd_val = '0;
    case (addr)
      AW'(ADDR_CAP):  rd_val = REG_W'(IRQGEN);
      AW'(ADDR_MASK): rd_val = REG_W'(mask_q);
      AW'(ADDR_POL):  rd_val = REG_W'(pol_q);
      AW'(ADDR_EDGE): rd_val = REG_W'(edge_q);
      AW'(ADDR_FLAG): rd_val = REG_W'(flag_i);
      default: begin
        for (int k = 0; k < NW; k++) begin
          if (addr == AW'(ADDR_MAP + k)) rd_val = map_word[k];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_val;
    else            rdata <= '0;
  end

  generate
    if (NL < REG_W) begin : g_sink
      logic unused_hi;
      assign unused_hi = ^wdata[REG_W-1:NL];
    end
  endgenerate

  // R7: the capability word reads back the build value regardless of writes.
  a_r7_cap_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == AW'(ADDR_CAP)) |=> (rdata == REG_W'(IRQGEN)));

  // R12: a cycle without a read strobe returns zero data.
  a_r12_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int            NL  = 16,
  parameter logic [NL-1:0] CAP = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NL-1:0] pin_i,
  input  logic [NL-1:0] mask_i,
  input  logic [NL-1:0] pol_i,
  input  logic [NL-1:0] edge_i,
  input  logic [NL-1:0] clr_i,
  output logic [NL-1:0] flag_o
);

  logic [NL-1:0] prev_q, flag_q, set_w;

  generate
    for (genvar g = 0; g < NL; g++) begin : g_line
      if (CAP[g]) begin : g_cap
        logic hit;
        always_comb begin
          if (edge_i[g])
            hit = pol_i[g] ? (pin_i[g] & ~prev_q[g]) : (~pin_i[g] & prev_q[g]);
          else
            hit = (pin_i[g] == pol_i[g]);
        end
        assign set_w[g] = mask_i[g] & hit;
      end else begin : g_nocap
        assign set_w[g] = 1'b0;
      end
    end
  endgenerate

  // A newly detected event wins over a same-cycle clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= pin_i;
      flag_q <= (flag_q & ~clr_i) | set_w;
    end
  end

  assign flag_o = flag_q;

  // R4: a cleared bit with no new event is gone one cycle later.
  a_r4_clear_takes: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flag_q & $past(clr_i & ~set_w)) == '0));

  // R6: a flag can only appear on an enabled line.
  a_r6_mask_gate: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(mask_i)) == '0));

  // R2: in edge mode a new flag needs a level change at the pin.
  a_r2_edge_needs_change: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flag_q & ~$past(flag_q) & $past(edge_i) & ~$past(pin_i ^ prev_q)) == '0));

  // R5: lines without capability never hold a flag.
  a_r5_no_cap_flag: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flag_q & ~CAP) == '0));

endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route
  import gpio_irq_pkg::*;
#(
  parameter int NL     = 16,
  parameter int NIRQ   = 32,
  parameter int IRQGEN = 2,
  parameter int BASE   = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NL-1:0]           flag_i,
  input  logic [NL-1:0][OFFW-1:0] map_i,
  output logic [NIRQ-1:0]         irq_o
);

  localparam int     IW   = (NIRQ > 1) ? $clog2(NIRQ) : 1;
  localparam route_e KIND = route_kind(IRQGEN);

  logic [IW-1:0]   dest [NL];
  logic [NIRQ-1:0] irq_d;

  generate
    for (genvar i = 0; i < NL; i++) begin : g_dest
      if (KIND == ROUTE_PER_LINE) begin : g_pl
        assign dest[i] = IW'((BASE + i) % NIRQ);
      end else if (KIND == ROUTE_SHARED) begin : g_sh
        assign dest[i] = IW'(BASE % NIRQ);
      end else begin : g_mp
        assign dest[i] = IW'((BASE + int'(map_i[i])) % NIRQ);
      end
    end
    if (KIND != ROUTE_MAPPED) begin : g_sink
      logic unused_map;
      assign unused_map = ^map_i;
    end
  endgenerate

  always_comb begin
    irq_d = '0;
    for (int o = 0; o < NIRQ; o++) begin
      for (int i = 0; i < NL; i++) begin
        if (flag_i[i] && (dest[i] == IW'(o))) irq_d[o] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= '0;
    else     irq_o <= irq_d;
  end

  // R11: no pending flag, no request one cycle later.
  a_r11_quiet: assert property (@(posedge clk) disable iff (rst)
    (flag_i == '0) |=> (irq_o == '0));

  // R11: any pending flag drives some request one cycle later.
  a_r11_follow: assert property (@(posedge clk) disable iff (rst)
    (flag_i != '0) |=> (irq_o != '0));

  generate
    if (KIND == ROUTE_SHARED) begin : g_chk_sh
      // R9: the shared mode never raises more than one request line.
      a_r9_single_line: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(irq_o) <= 1));
    end
  endgenerate

endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpio_irq_pkg::*;
#(
  parameter int            NL       = 16,
  parameter int            NIRQ     = 32,
  parameter int            AW       = 4,
  parameter int            IRQGEN   = 2,
  parameter int            IRQ_BASE = 0,
  parameter logic [NL-1:0] IRQ_CAP  = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NL-1:0]   pin_i,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output logic [NIRQ-1:0] irq_o
);

  logic [NL-1:0] mask_w, pol_w, edge_w, clr_w, flag_w;
  logic [NL-1:0][OFFW-1:0] map_w;

  gpio_irq_regs #(.NL(NL), .AW(AW), .IRQGEN(IRQGEN), .CAP(IRQ_CAP)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .flag_i(flag_w), .rdata(rdata), .mask_o(mask_w),
    .pol_o(pol_w), .edge_o(edge_w), .clr_o(clr_w), .map_o(map_w)
  );

  gpio_irq_detect #(.NL(NL), .CAP(IRQ_CAP)) u_detect (
    .clk(clk), .rst(rst), .pin_i(pin_i), .mask_i(mask_w), .pol_i(pol_w),
    .edge_i(edge_w), .clr_i(clr_w), .flag_o(flag_w)
  );

  gpio_irq_route #(.NL(NL), .NIRQ(NIRQ), .IRQGEN(IRQGEN), .BASE(IRQ_BASE)) u_route (
    .clk(clk), .rst(rst), .flag_i(flag_w), .map_i(map_w), .irq_o(irq_o)
  );

endmodule

// File: tb/gpio_irq_router_tb.sv
module gpio_irq_router_tb;

  localparam int NL = 16, NIRQ = 32, AW = 4, BASE = 3;
  localparam logic [NL-1:0] CAP = 16'hB7E5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic we = 1'b0, re = 1'b0;
  logic [AW-1:0] a = '0;
  logic [31:0] d = '0;
  logic [NL-1:0] pins = '0;
  logic [31:0] rd_m, rd_p, rd_s;
  logic [NIRQ-1:0] irq_m, irq_p, irq_s;

  gpio_irq_router #(.NL(NL), .NIRQ(NIRQ), .AW(AW), .IRQGEN(5), .IRQ_BASE(BASE), .IRQ_CAP(CAP)) u_dut (
    .clk(clk), .rst(rst), .pin_i(pins), .wr_en(we), .rd_en(re), .addr(a),
    .wdata(d), .rdata(rd_m), .irq_o(irq_m));
  gpio_irq_router #(.NL(NL), .NIRQ(NIRQ), .AW(AW), .IRQGEN(0), .IRQ_BASE(BASE), .IRQ_CAP(CAP)) u_dut_pl (
    .clk(clk), .rst(rst), .pin_i(pins), .wr_en(we), .rd_en(re), .addr(a),
    .wdata(d), .rdata(rd_p), .irq_o(irq_p));
  gpio_irq_router #(.NL(NL), .NIRQ(NIRQ), .AW(AW), .IRQGEN(1), .IRQ_BASE(BASE), .IRQ_CAP(CAP)) u_dut_sh (
    .clk(clk), .rst(rst), .pin_i(pins), .wr_en(we), .rd_en(re), .addr(a),
    .wdata(d), .rdata(rd_s), .irq_o(irq_s));

  int total = 0, bad = 0;
  logic [NL-1:0] mask_m, pol_m, edge_m, flag_m, prev_m;
  logic [4:0] map_m [NL];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NL-1:0] events(input logic [NL-1:0] p);
    logic [NL-1:0] s = '0;
    for (int i = 0; i < NL; i++) begin
      logic h;
      if (edge_m[i]) h = pol_m[i] ? (p[i] & ~prev_m[i]) : (~p[i] & prev_m[i]);
      else           h = (p[i] == pol_m[i]);
      s[i] = h & mask_m[i] & CAP[i];
    end
    return s;
  endfunction

  // mode: 0 per line, 1 shared, 2 mapped
  function automatic logic [31:0] steer(input int mode, input logic [NL-1:0] f);
    logic [31:0] o = '0;
    for (int i = 0; i < NL; i++) begin
      if (f[i]) begin
        if (mode == 0)      o[(BASE + i) % NIRQ] = 1'b1;
        else if (mode == 1) o[BASE % NIRQ] = 1'b1;
        else                o[(BASE + int'(map_m[i])) % NIRQ] = 1'b1;
      end
    end
    return o;
  endfunction

  function automatic logic [31:0] rdval(input int mode, input logic [AW-1:0] ad);
    logic [31:0] v = '0;
    case (ad)
      4'd0: v = (mode == 2) ? 32'd5 : (mode == 0 ? 32'd0 : 32'd1);
      4'd1: v = 32'(mask_m);
      4'd2: v = 32'(pol_m);
      4'd3: v = 32'(edge_m);
      4'd4: v = 32'(flag_m);
      default: begin
        if (mode == 2 && ad >= 4'd8 && ad < 4'd8 + NL/4) begin
          for (int j = 0; j < 4; j++) v[(24-8*j) +: 5] = map_m[4*(ad-8)+j];
        end
      end
    endcase
    return v;
  endfunction

  function automatic string tagof(input logic [AW-1:0] ad);
    if (ad == 0) return "R7";
    if (ad == 1) return "R6";
    if (ad == 2 || ad == 3) return "R5";
    if (ad == 4) return "R4";
    if (ad >= 8 && ad < 12) return "R10";
    return "R12";
  endfunction

  task automatic step(input logic w, input logic r, input logic [AW-1:0] ad,
                      input logic [31:0] dat, input logic [NL-1:0] p);
    logic [31:0] e_m, e_p, e_s, x_m, x_p, x_s;
    logic [NL-1:0] s, clr;
    @(negedge clk);
    we = w; re = r; a = ad; d = dat; pins = p;
    @(posedge clk);
    #1;
    e_m = steer(2, flag_m); e_p = steer(0, flag_m); e_s = steer(1, flag_m);
    x_m = rdval(2, ad); x_p = rdval(0, ad); x_s = rdval(1, ad);
    s = events(p);
    clr = (w && ad == 4) ? dat[NL-1:0] : '0;
    flag_m = (flag_m & ~clr) | s;
    prev_m = p;
    if (w) begin
      if (ad == 1) mask_m = dat[NL-1:0] & CAP;
      if (ad == 2) pol_m  = dat[NL-1:0] & CAP;
      if (ad == 3) edge_m = dat[NL-1:0] & CAP;
      if (ad >= 8 && ad < 12)
        for (int j = 0; j < 4; j++) map_m[4*(ad-8)+j] = dat[(24-8*j) +: 5];
    end
    check("R10 R11 mapped irq", 32'(irq_m), e_m);
    check("R8 R11 per-line irq", 32'(irq_p), e_p);
    check("R9 R11 shared irq", 32'(irq_s), e_s);
    if (r) begin
      check({tagof(ad), " read mapped"}, rd_m, x_m);
      check({tagof(ad), " read per-line"}, rd_p, x_p);
      check({tagof(ad), " read shared"}, rd_s, x_s);
    end else begin
      check("R12 idle rdata", rd_m, 32'd0);
    end
  endtask

  bit done = 1'b0;

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    mask_m = '0; pol_m = '0; edge_m = '0; flag_m = '0; prev_m = '0;
    for (int i = 0; i < NL; i++) map_m[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1: reset state at the ports
    check("R1 reset irq mapped", 32'(irq_m), 32'd0);
    check("R1 reset irq per-line", 32'(irq_p), 32'd0);
    check("R1 reset rdata", rd_m, 32'd0);
    for (int k = 1; k <= 4; k++) begin
      step(1'b0, 1'b1, AW'(k), 32'd0, '0);
      check("R1 reset register", rd_m, 32'd0);
    end

    // R5: only capable lines implemented
    step(1'b1, 1'b0, 4'd2, 32'hFFFF_FFFF, '0);
    step(1'b0, 1'b1, 4'd2, 32'd0, '0);
    check("R5 polarity readback", rd_m, 32'(CAP));
    step(1'b1, 1'b0, 4'd3, 32'hFFFF_FFFF, '0);
    step(1'b0, 1'b1, 4'd3, 32'd0, '0);
    check("R5 edge readback", rd_m, 32'(CAP));

    // R7: capability word ignores writes
    step(1'b1, 1'b0, 4'd0, 32'hFFFF_FFFF, '0);
    step(1'b0, 1'b1, 4'd0, 32'd0, '0);
    check("R7 capability value", rd_m, 32'd5);

    // R3: level mode, high active, re-raise after clear
    step(1'b1, 1'b0, 4'd3, 32'd0, '0);
    step(1'b1, 1'b0, 4'd1, 32'hFFFF, '0);
    step(1'b0, 1'b0, 4'd0, 32'd0, 16'h0001);
    step(1'b1, 1'b0, 4'd4, 32'h0000_0001, 16'h0001);
    step(1'b0, 1'b1, 4'd4, 32'd0, 16'h0001);
    check("R3 level flag held after clear", rd_m & 32'h1, 32'h1);
    step(1'b0, 1'b0, 4'd0, 32'd0, 16'h0000);
    step(1'b1, 1'b0, 4'd4, 32'h0000_0001, 16'h0000);
    step(1'b0, 1'b1, 4'd4, 32'd0, 16'h0000);
    check("R4 clear after level gone", rd_m & 32'h1, 32'h0);

    // R2: edge mode, rising on line 2, falling on line 5
    step(1'b1, 1'b0, 4'd3, 32'hFFFF, 16'h0020);
    step(1'b1, 1'b0, 4'd2, 32'h0000_0004, 16'h0020);
    step(1'b1, 1'b0, 4'd4, 32'hFFFF, 16'h0020);
    step(1'b0, 1'b1, 4'd4, 32'd0, 16'h0020);
    check("R2 steady level no edge", rd_m, 32'd0);
    step(1'b0, 1'b0, 4'd0, 32'd0, 16'h0004);
    step(1'b0, 1'b1, 4'd4, 32'd0, 16'h0000);
    check("R2 rising and falling edges", rd_m, 32'h0000_0024);

    // R6: disabling enable keeps pending flag
    step(1'b1, 1'b0, 4'd1, 32'd0, 16'h0000);
    step(1'b0, 1'b1, 4'd4, 32'd0, 16'h0004);
    check("R6 pending survives disable", rd_m, 32'h0000_0024);

    // R10: map with wrapping offsets
    step(1'b1, 1'b0, 4'd8, 32'h1F1D_0201, '0);
    step(1'b0, 1'b1, 4'd8, 32'd0, '0);
    check("R10 map packing", rd_m, 32'h1F1D_0201);

    for (int n = 0; n < 4000; n++) begin
      int op = int'($urandom_range(0, 9));
      logic [NL-1:0] np = pins ^ (NL'($urandom) & NL'($urandom) & NL'($urandom));
      logic [AW-1:0] ra = AW'($urandom);
      logic [31:0] rdat = $urandom;
      if (op < 4)      step(1'b0, 1'b0, ra, rdat, np);
      else if (op < 6) step(1'b1, 1'b0, 4'd4, rdat, np);
      else if (op < 8) step(1'b0, 1'b1, ra, 32'd0, np);
      else             step(1'b1, 1'b0, ra, rdat, np);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule